// File: doc/BRIEF.md
# Level-Sensed DMA Request Pacer

This block turns an active-low request line from a peripheral into paced single-address DMA transfers, one bus cycle per accepted request. Software enables the channel with a register write. The write's closing strobe loads a transfer count and opens acceptance. From the next clock edge on, the request line is sampled on every rising edge while acceptance is open. A low level is held inside the block as a pending request, and sampling stops.

A pending request waits for the end of the bus cycle that is under way. At that edge it is cleared and activation begins. A bus-release phase follows, then a fixed-length DMA single cycle, during which the acknowledge output tells the peripheral that its data is being moved. When the single cycle completes, acceptance reopens. A line that is still low is taken again on that same edge, so a request held low produces back-to-back transfers. Each completed cycle decrements the count. At zero the block raises its done flag, drops the enable and stops sampling.

Top module: `lvlreq_dma_ctrl`

## Requirements
- R1: After reset, `chan_state` is 0 (idle), and `dack`, `busy` and `done` are all low.
- R2: Acceptance opens only after an `en_set` pulse. A low `req_n` on the same edge that registers `en_set` is not taken, and the first sample is taken on the following edge. While the channel is disabled, `req_n` is never taken.
- R3: When `req_n` is low at a rising edge while acceptance is open, `chan_state` becomes 1 (pending). While `chan_state` is 1, 2 or 3, `req_n` has no effect.
- R4: A pending request stays pending until `bus_end` is high at a rising edge. `chan_state` then becomes 2 (bus release) for `REL_CYC` cycles (default 2), with `busy` high and `dack` low.
- R5: After the release phase, `chan_state` is 3 (single cycle) for `SGL_CYC` cycles (default 2). `dack` is high only in this state, and `busy` stays high. The edge that samples the request and the edge that raises `dack` are at least 3 cycles apart.
- R6: Exactly one single cycle is run per accepted request. On the edge that ends the single cycle, acceptance reopens. If `req_n` is low on that edge, `chan_state` goes straight to 1.
- R7: `xfer_cnt` is loaded on `en_set` and decremented at the end of each single cycle. When the last transfer ends, `done` rises, the enable clears and `req_n` is no longer taken.
- R8: An `en_clr` pulse while a request is pending discards it, and `chan_state` returns to 0 without `dack`. An `en_clr` pulse during the release or single phase lets that cycle finish, after which the channel idles with no new request taken.
- R9: An `en_set` with a count of 0 raises `done` on the next edge and opens no acceptance. A later `en_set` with a nonzero count clears `done`.
- R10: When `en_set` and `en_clr` are high on the same edge, the clear wins and the channel stays disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_set | input | 1 | One-cycle pulse at the end of the enabling register write |
| en_clr | input | 1 | One-cycle pulse at the end of a disabling register write |
| xfer_cnt | input | CNT_W | Number of transfers, loaded on `en_set` |
| req_n | input | 1 | Active-low transfer request from the peripheral |
| bus_end | input | 1 | High on the last cycle of the bus cycle currently in progress |
| dack | output | 1 | Transfer acknowledge, high during the DMA single cycle |
| busy | output | 1 | Bus request / busy, high during release and single phases |
| chan_state | output | 2 | 0 idle, 1 pending, 2 bus release, 3 single cycle |
| done | output | 1 | Transfer count exhausted |

## Verification
On every cycle, the assertions check the step-by-step legality of the sequence. A sampled request must become pending, and a pending request holds until the bus cycle ends or the enable is withdrawn. An acknowledge must be preceded by two release cycles and a pending cycle, and must last at least two cycles. A discarded request must fall back to idle, and a rising done flag must follow the end of a DMA cycle. Only the bench's scenarios can show the behaviour that depends on history. This covers the one-edge delay before sampling starts after enabling, the back-to-back relatch on a held request, count exhaustion at exactly the programmed number of cycles, the completion of a cycle interrupted by a disable, and the priority of clear over set.

// File: rtl/lvlreq_pkg.sv
package lvlreq_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_PEND = 2'd1,
        CH_REL  = 2'd2,
        CH_SGL  = 2'd3
    } ch_state_e;

endpackage

// File: rtl/lvlreq_phase_tmr.sv
module lvlreq_phase_tmr #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);

    typedef struct packed {
        logic [W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired = (tmr_q.cnt == '0);

endmodule

// File: rtl/lvlreq_xfer_cnt.sv
module lvlreq_xfer_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [CNT_W-1:0] cnt_in,
    input  logic             xfer_end,
    output logic             en,
    output logic             last,
    output logic             done
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             en;
        logic             done;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        // Completed DMA cycle: count down, close the channel on the last one
        if (xfer_end && (cnt_q.cnt != '0)) begin
            cnt_d.cnt = cnt_q.cnt - 1'b1;
            if (cnt_q.cnt == CNT_W'(1)) begin
                cnt_d.en   = 1'b0;
                cnt_d.done = 1'b1;
            end
        end
        // Disable has priority over a simultaneous enable
        if (en_clr) begin
            cnt_d.en = 1'b0;
        end else if (en_set) begin
            cnt_d.cnt  = cnt_in;
            cnt_d.en   = (cnt_in != '0);
            cnt_d.done = (cnt_in == '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign en   = cnt_q.en;
    assign last = (cnt_q.cnt <= CNT_W'(1));
    assign done = cnt_q.done;

endmodule

// File: rtl/lvlreq_seq.sv
module lvlreq_seq
    import lvlreq_pkg::*;
#(
    parameter int REL_CYC = 2,
    parameter int SGL_CYC = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      en_clr_i,
    input  logic      last_i,
    input  logic      req_n_i,
    input  logic      bus_end_i,
    output ch_state_e state_o,
    output logic      xfer_end_o
);

    localparam int MAXC = (REL_CYC > SGL_CYC) ? REL_CYC : SGL_CYC;
    localparam int TW   = $clog2(MAXC) + 1;

    typedef struct packed {
        ch_state_e st;
    } seq_t;

    seq_t          seq_d, seq_q;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          en_keep;

    lvlreq_phase_tmr #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    always_comb begin
        seq_d      = seq_q;
        tmr_load   = 1'b0;
        tmr_val    = '0;
        xfer_end_o = 1'b0;
        en_keep    = en_i && !en_clr_i;
        case (seq_q.st)
            CH_IDLE: begin
                if (en_keep && !req_n_i) begin
                    seq_d.st = CH_PEND;
                end
            end
            CH_PEND: begin
                if (!en_keep) begin
                    seq_d.st = CH_IDLE;
                end else if (bus_end_i) begin
                    seq_d.st = CH_REL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(REL_CYC - 1);
                end
            end
            CH_REL: begin
                if (tmr_exp) begin
                    seq_d.st = CH_SGL;
                    tmr_load = 1'b1;
                    tmr_val  = TW'(SGL_CYC - 1);
                end
            end
            CH_SGL: begin
                if (tmr_exp) begin
                    xfer_end_o = 1'b1;
                    if (en_keep && !last_i && !req_n_i) begin
                        seq_d.st = CH_PEND;
                    end else begin
                        seq_d.st = CH_IDLE;
                    end
                end
            end
            default: seq_d.st = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st <= CH_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign state_o = seq_q.st;

endmodule

// File: rtl/lvlreq_dma_ctrl.sv
module lvlreq_dma_ctrl
    import lvlreq_pkg::*;
#(
    parameter int CNT_W   = 8,
    parameter int REL_CYC = 2,
    parameter int SGL_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_set,
    input  logic             en_clr,
    input  logic [CNT_W-1:0] xfer_cnt,
    input  logic             req_n,
    input  logic             bus_end,
    output logic             dack,
    output logic             busy,
    output logic [1:0]       chan_state,
    output logic             done
);

    ch_state_e st_w;
    logic      en_w;
    logic      last_w;
    logic      xfer_end_w;

    lvlreq_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_set   (en_set),
        .en_clr   (en_clr),
        .cnt_in   (xfer_cnt),
        .xfer_end (xfer_end_w),
        .en       (en_w),
        .last     (last_w),
        .done     (done)
    );

    lvlreq_seq #(.REL_CYC(REL_CYC), .SGL_CYC(SGL_CYC)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_w),
        .en_clr_i   (en_clr),
        .last_i     (last_w),
        .req_n_i    (req_n),
        .bus_end_i  (bus_end),
        .state_o    (st_w),
        .xfer_end_o (xfer_end_w)
    );

    assign chan_state = st_w;
    assign dack       = (st_w == CH_SGL);
    assign busy       = (st_w == CH_REL) || (st_w == CH_SGL);

endmodule

// File: rtl/lvlreq_dma_ctrl_chk.sv
module lvlreq_dma_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       en_set,
    input logic       en_clr,
    input logic       req_n,
    input logic       bus_end,
    input logic       dack,
    input logic       busy,
    input logic [1:0] chan_state,
    input logic       done,
    input logic       en_q
);

    // R3
    sample_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_state == 2'd0 && en_q && !en_clr && !req_n) |=> (chan_state == 2'd1));

    // R4
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_state == 2'd1 && en_q && !en_clr && !bus_end) |=> (chan_state == 2'd1));

    // R5
    min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dack) |-> ($past(busy, 1) && $past(busy, 2) && ($past(chan_state, 3) == 2'd1)));

    // R5
    dack_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dack) |=> (dack && busy));

    // R8
    discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_state == 2'd1 && en_clr) |=> (chan_state == 2'd0 && !busy));

    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done) && !$past(en_set)) |-> $past(dack));

endmodule

bind lvlreq_dma_ctrl lvlreq_dma_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_set     (en_set),
    .en_clr     (en_clr),
    .req_n      (req_n),
    .bus_end    (bus_end),
    .dack       (dack),
    .busy       (busy),
    .chan_state (chan_state),
    .done       (done),
    .en_q       (en_w)
);

// File: tb/lvlreq_dma_ctrl_test.sv
`timescale 1ns/1ps
module lvlreq_dma_ctrl_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_set = 1'b0;
    logic       en_clr = 1'b0;
    logic [7:0] xfer_cnt = '0;
    logic       req_n = 1'b1;
    logic       bus_end = 1'b0;
    logic       dack;
    logic       busy;
    logic [1:0] chan_state;
    logic       done;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lvlreq_dma_ctrl uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_set     (en_set),
        .en_clr     (en_clr),
        .xfer_cnt   (xfer_cnt),
        .req_n      (req_n),
        .bus_end    (bus_end),
        .dack       (dack),
        .busy       (busy),
        .chan_state (chan_state),
        .done       (done)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Packs {chan_state, dack, busy}
    task automatic chk_st(input string tag, input int st, input int dk, input int bs);
        chk(tag, int'({chan_state, dack, busy}), (st << 2) | (dk << 1) | bs);
    endtask

    task automatic quiesce();
        req_n = 1'b1; bus_end = 1'b0; en_set = 1'b0;
        en_clr = 1'b1; step(1);
        en_clr = 1'b0; step(1);
    endtask

    task automatic t_reset();
        req_n = 1'b0;
        step(1);
        chk_st("R1 state in reset", 0, 0, 0);
        rst_n = 1'b1;
        step(3);
        chk_st("R1 idle after reset", 0, 0, 0);
        chk("R1 done after reset", int'(done), 0);
        chk_st("R2 no sampling while disabled", 0, 0, 0);
    endtask

    task automatic t_enable_and_single();
        quiesce();
        en_set = 1'b1; xfer_cnt = 8'd3; req_n = 1'b0;
        step(1);
        chk_st("R2 no take on enable edge", 0, 0, 0);
        en_set = 1'b0;
        step(1);
        chk_st("R3 low level taken", 1, 0, 0);
        req_n = 1'b1; step(1); req_n = 1'b0; step(1); req_n = 1'b1; step(1);
        chk_st("R3 R4 pending held, pin ignored", 1, 0, 0);
        bus_end = 1'b1;
        step(1);
        chk_st("R4 release 1", 2, 0, 1);
        bus_end = 1'b0;
        step(1);
        chk_st("R4 release 2", 2, 0, 1);
        step(1);
        chk_st("R5 single 1", 3, 1, 1);
        step(1);
        chk_st("R5 single 2", 3, 1, 1);
        step(1);
        chk_st("R6 idle after single", 0, 0, 0);
        step(2);
        chk_st("R6 stays idle with pin high", 0, 0, 0);
        chk("R7 not done after 1 of 3", int'(done), 0);
    endtask

    task automatic t_back_to_back();
        quiesce();
        en_set = 1'b1; xfer_cnt = 8'd2;
        step(1);
        en_set = 1'b0; req_n = 1'b0; bus_end = 1'b1;
        step(1);
        chk_st("R3 take", 1, 0, 0);
        step(1); chk_st("R4 rel a", 2, 0, 1);
        step(1); chk_st("R4 rel b", 2, 0, 1);
        step(1); chk_st("R5 dack 3 cycles after sample", 3, 1, 1);
        step(1); chk_st("R5 dack second", 3, 1, 1);
        step(1); chk_st("R6 relatch same edge", 1, 0, 0);
        chk("R7 not done mid run", int'(done), 0);
        step(1); chk_st("R4 rel c", 2, 0, 1);
        step(1); chk_st("R4 rel d", 2, 0, 1);
        step(1); chk_st("R5 dack again", 3, 1, 1);
        step(1); chk_st("R5 dack again 2", 3, 1, 1);
        step(1);
        chk_st("R7 idle after last", 0, 0, 0);
        chk("R7 done raised", int'(done), 1);
        step(4);
        chk_st("R7 no take after count out", 0, 0, 0);
        bus_end = 1'b0;
    endtask

    task automatic t_zero_count();
        quiesce();
        en_set = 1'b1; xfer_cnt = 8'd0; req_n = 1'b0;
        step(1);
        chk("R9 done on zero count", int'(done), 1);
        en_set = 1'b0;
        step(3);
        chk_st("R9 no take on zero count", 0, 0, 0);
        en_set = 1'b1; xfer_cnt = 8'd4;
        step(1);
        chk("R9 done cleared by enable", int'(done), 0);
        en_set = 1'b0;
        step(1);
        chk_st("R9 take after reload", 1, 0, 0);
    endtask

    task automatic t_clear_pending();
        quiesce();
        en_set = 1'b1; xfer_cnt = 8'd2; req_n = 1'b0;
        step(1);
        en_set = 1'b0;
        step(1);
        chk_st("R8 pending before clear", 1, 0, 0);
        en_clr = 1'b1;
        step(1);
        chk_st("R8 pending discarded", 0, 0, 0);
        en_clr = 1'b0; bus_end = 1'b1;
        step(4);
        chk_st("R8 no dack after discard", 0, 0, 0);
        bus_end = 1'b0;
    endtask

    task automatic t_clear_single();
        quiesce();
        en_set = 1'b1; xfer_cnt = 8'd5; req_n = 1'b0; bus_end = 1'b1;
        step(1);
        en_set = 1'b0;
        step(3);
        step(1);
        chk_st("R8 in single before clear", 3, 1, 1);
        en_clr = 1'b1;
        step(1);
        chk_st("R8 single finishes", 3, 1, 1);
        en_clr = 1'b0;
        step(1);
        chk_st("R8 idle after finish", 0, 0, 0);
        step(3);
        chk_st("R8 no retake after clear", 0, 0, 0);
        bus_end = 1'b0;
    endtask

    task automatic t_priority();
        quiesce();
        en_set = 1'b1; en_clr = 1'b1; xfer_cnt = 8'd3; req_n = 1'b0;
        step(1);
        en_set = 1'b0; en_clr = 1'b0;
        step(3);
        chk_st("R10 clear beats set", 0, 0, 0);
    endtask

    initial begin
        step(2);
        t_reset();
        t_enable_and_single();
        t_back_to_back();
        t_zero_count();
        t_clear_pending();
        t_clear_single();
        t_priority();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule